// File: doc/BRIEF.md
# Remote DMA data port with interrupt status

This block gives a host a single data port through which it moves bytes, 16-bit words or 32-bit words to and from the local memory of a network controller. A 16-bit remote address register points at the next memory byte and moves forward by the access size after every access. When it reaches the ring stop page, it jumps back to the ring start page. A 16-bit remote byte count register counts the transfer down. When the count runs out, the block stops at zero and raises a DMA-complete status bit.

The block also holds the command, interrupt status and interrupt mask registers, and it drives the interrupt line. The transmit and receive engines are not part of this block. They report events through single-cycle set pulses on the status bits. Memory sits outside the block, behind a byte-lane port. Lane i of that port addresses the byte at the port address plus i.

Top module: `rdma_port`

## Requirements
- R1: Valid memory is byte addresses below PROM_BYTES (32) and addresses from PMEM_START up to but not including MEM_BYTES. Each lane of an access is judged on its own. A read lane at an invalid address returns 0xFF, and a write lane at an invalid address is not written (its mem_wmask bit is 0).
- R2: host_size selects the access: 0 = byte, 1 = word, 2 or 3 = doubleword. Word and doubleword accesses clear address bit 0. Bytes are little-endian: data bits [8i+7:8i] belong to address base+i. Read lanes above the access size return 0.
- R3: After each read access, and after each write access made while the count is nonzero, the address advances by the access size. The advance starts from the unaligned address. If the result equals ring_stop*256, the address becomes ring_start*256.
- R4: After an access, if the count was at most the access size, the count becomes 0 and status bit 6 (DMA complete) is set. Otherwise the count drops by the access size.
- R5: A data-port write while the count is 0 is ignored completely: there is no memory write, and neither the address nor the count changes.
- R6: A command write with bit 0 (stop) clear, and with bit 3 (remote read) or bit 4 (remote write) set, sets status bit 6 when the count is 0.
- R7: A status register write clears each status bit in [6:0] where the written byte holds a 1. A pulse on evt_set[k] sets status bit k, and a set wins over a clear in the same cycle.
- R8: irq is 1 exactly when (status AND mask) bits [6:0] are nonzero. Status bit 7 never raises it.
- R9: After reset, status = 0x80, mask = 0x00 and command = 0x22. A command write with bit 0 clear clears status bit 7.
- R10: The address and the count each load one byte per strobe, low byte or high byte. A strobe leaves the other byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| host_rd | input | 1 | data-port read strobe |
| host_wr | input | 1 | data-port write strobe |
| host_size | input | 2 | access size: 0 byte, 1 word, 2/3 doubleword |
| host_wdata | input | 32 | data-port write data |
| host_rdata | output | 32 | data-port read data, combinational |
| ld_data | input | 8 | byte for register loads |
| sar_lo_ld | input | 1 | load address low byte |
| sar_hi_ld | input | 1 | load address high byte |
| cnt_lo_ld | input | 1 | load count low byte |
| cnt_hi_ld | input | 1 | load count high byte |
| cmd_ld | input | 1 | write command register |
| isr_ld | input | 1 | write-one-to-clear status register |
| imr_ld | input | 1 | write mask register |
| ring_start | input | 8 | ring start page |
| ring_stop | input | 8 | ring stop page |
| evt_set | input | 7 | status bit set pulses from other engines |
| mem_addr | output | AW | memory byte address of lane 0 |
| mem_we | output | 1 | memory write enable |
| mem_wmask | output | 4 | per-lane write enable |
| mem_wdata | output | 32 | memory write data |
| mem_rdata | input | 32 | memory read data, combinational |
| sar | output | AW | remote address register |
| cnt | output | 16 | remote byte count register |
| cmd | output | 8 | command register |
| isr | output | 8 | interrupt status register |
| imr | output | 8 | interrupt mask register |
| irq | output | 1 | interrupt request |

## Verification
Each access size is swept over a packet-memory block in two passes: first writes, then reads back. This shows whether lane order, address alignment and the step size agree with one another. Reads of every size are also swept across the edges of both valid windows. Because each lane is judged on its own there, the sweep separates a per-lane check from a per-access check. Separate sequences cover the following cases:
- the ring wrap, hit exactly by both byte and doubleword steps;
- counts just below, equal to and just above the access size;
- a write at zero count, compared with a read at zero count;
- status set and clear pulses landing in the same cycle, and mask patterns that include bit 7.

// File: rtl/rdma_port.sv
module rdma_port #(
  parameter int AW = 16,
  parameter int MEM_BYTES = 32768,
  parameter int PROM_BYTES = 32,
  parameter int PMEM_START = 16384
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [1:0]    host_size,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic [7:0]    ld_data,
  input  logic          sar_lo_ld,
  input  logic          sar_hi_ld,
  input  logic          cnt_lo_ld,
  input  logic          cnt_hi_ld,
  input  logic          cmd_ld,
  input  logic          isr_ld,
  input  logic          imr_ld,
  input  logic [7:0]    ring_start,
  input  logic [7:0]    ring_stop,
  input  logic [6:0]    evt_set,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [3:0]    mem_wmask,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [AW-1:0] sar,
  output logic [15:0]   cnt,
  output logic [7:0]    cmd,
  output logic [7:0]    isr,
  output logic [7:0]    imr,
  output logic          irq
);
  localparam logic [AW-1:0] STOP_PAD = '0;

  logic [2:0]    nbytes;
  logic [AW-1:0] base, sar_inc, sar_next, ring_lo, ring_hi;
  logic          wr_ok, go, done, cmd_rdc;
  logic [7:0]    isr_next;

  assign nbytes   = (host_size == 2'd0) ? 3'd1 : (host_size == 2'd1) ? 3'd2 : 3'd4;
  assign base     = (host_size == 2'd0) ? sar : {sar[AW-1:1], 1'b0};
  assign wr_ok    = host_wr && (cnt != 16'd0);
  assign go       = host_rd || wr_ok;
  assign done     = go && (cnt <= {13'd0, nbytes});
  assign ring_lo  = STOP_PAD | (AW'(ring_start) << 8);
  assign ring_hi  = STOP_PAD | (AW'(ring_stop) << 8);
  assign sar_inc  = sar + AW'(nbytes);
  assign sar_next = (sar_inc == ring_hi) ? ring_lo : sar_inc;
  assign cmd_rdc  = cmd_ld && !ld_data[0] && (ld_data[4:3] != 2'b00) && (cnt == 16'd0);

  assign mem_addr  = base;
  assign mem_we    = wr_ok && !host_rd;
  assign mem_wdata = host_wdata;

  for (genvar i = 0; i < 4; i++) begin : g_lane
    logic [AW:0] a;
    logic        ok, used;
    assign a    = {1'b0, base} + (AW+1)'(i);
    assign ok   = (a < (AW+1)'(PROM_BYTES)) ||
                  ((a >= (AW+1)'(PMEM_START)) && (a < (AW+1)'(MEM_BYTES)));
    assign used = i < int'(nbytes);
    assign host_rdata[8*i +: 8] = !used ? 8'h00 : ok ? mem_rdata[8*i +: 8] : 8'hFF;
    assign mem_wmask[i] = used && ok && mem_we;
  end

  always_comb begin
    isr_next = isr;
    if (cmd_ld && !ld_data[0]) isr_next[7] = 1'b0;
    if (isr_ld) isr_next[6:0] = isr_next[6:0] & ~ld_data[6:0];
    isr_next[6:0] = isr_next[6:0] | evt_set;
    if (done || cmd_rdc) isr_next[6] = 1'b1;
  end

  assign irq = |(isr[6:0] & imr[6:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sar <= '0;
      cnt <= '0;
      cmd <= 8'h22;
      isr <= 8'h80;
      imr <= 8'h00;
    end else begin
      isr <= isr_next;
      if (cmd_ld) cmd <= ld_data;
      if (imr_ld) imr <= ld_data;
      if (sar_lo_ld || sar_hi_ld) begin
        if (sar_lo_ld) sar[7:0] <= ld_data;
        if (sar_hi_ld) sar[15:8] <= ld_data;
      end else if (go) begin
        sar <= sar_next;
      end
      if (cnt_lo_ld || cnt_hi_ld) begin
        if (cnt_lo_ld) cnt[7:0] <= ld_data;
        if (cnt_hi_ld) cnt[15:8] <= ld_data;
      end else if (go) begin
        cnt <= done ? 16'd0 : cnt - {13'd0, nbytes};
      end
    end
  end
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk #(parameter int AW = 16) (
  input logic          clk,
  input logic          rst,
  input logic          host_rd,
  input logic          host_wr,
  input logic [1:0]    host_size,
  input logic          sar_lo_ld,
  input logic          sar_hi_ld,
  input logic          cnt_lo_ld,
  input logic          cnt_hi_ld,
  input logic          isr_ld,
  input logic [7:0]    ld_data,
  input logic [6:0]    evt_set,
  input logic          mem_we,
  input logic [AW-1:0] sar,
  input logic [15:0]   cnt,
  input logic [7:0]    cmd,
  input logic [7:0]    isr,
  input logic [7:0]    imr
);
  logic [15:0] sz;
  logic        no_ld;
  assign sz    = (host_size == 2'd0) ? 16'd1 : (host_size == 2'd1) ? 16'd2 : 16'd4;
  assign no_ld = !(sar_lo_ld || sar_hi_ld || cnt_lo_ld || cnt_hi_ld);

  a_r4_count_saturate: assert property (@(posedge clk) disable iff (rst)
    ((host_rd || (host_wr && cnt != 0)) && no_ld && cnt <= sz) |=> (cnt == 16'd0 && isr[6]));

  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    (host_rd && no_ld && cnt > sz) |=> (cnt == $past(cnt) - $past(sz)));

  a_r5_zero_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_rd && cnt == 0 && no_ld) |=> ($stable(sar) && cnt == 16'd0));

  a_r5_no_mem_write: assert property (@(posedge clk) disable iff (rst)
    (host_wr && cnt == 0) |-> !mem_we);

  a_r7_clear_bits: assert property (@(posedge clk) disable iff (rst)
    (isr_ld && evt_set == 7'd0 && !host_rd && !host_wr) |=> ((isr[6:0] & $past(ld_data[6:0])) == 7'd0));

  a_r9_reset_values: assert property (@(posedge clk)
    rst |=> (isr == 8'h80 && imr == 8'h00 && cmd == 8'h22));
endmodule

bind rdma_port rdma_port_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr), .host_size(host_size),
  .sar_lo_ld(sar_lo_ld), .sar_hi_ld(sar_hi_ld), .cnt_lo_ld(cnt_lo_ld), .cnt_hi_ld(cnt_hi_ld),
  .isr_ld(isr_ld), .ld_data(ld_data), .evt_set(evt_set), .mem_we(mem_we),
  .sar(sar), .cnt(cnt), .cmd(cmd), .isr(isr), .imr(imr)
);

// File: tb/rdma_port_test.sv
`timescale 1ns/1ps
module rdma_port_test;
  localparam int MB = 1024, PB = 32, PS = 512;
  logic clk = 0, rst = 1;
  logic host_rd = 0, host_wr = 0;
  logic [1:0] host_size = 0;
  logic [31:0] host_wdata = 0, host_rdata, mem_wdata, mem_rdata;
  logic [7:0] ld_data = 0, ring_start = 8'h02, ring_stop = 8'h04;
  logic sar_lo_ld = 0, sar_hi_ld = 0, cnt_lo_ld = 0, cnt_hi_ld = 0;
  logic cmd_ld = 0, isr_ld = 0, imr_ld = 0;
  logic [6:0] evt_set = 0;
  logic [15:0] mem_addr, sar, cnt;
  logic mem_we, irq;
  logic [3:0] mem_wmask;
  logic [7:0] cmd, isr, imr;

  logic [7:0] mem [0:MB-1];
  logic [7:0] shadow [0:MB-1];
  int nchk = 0, nfail = 0;
  logic [15:0] e_sar, e_cnt;
  logic [7:0] e_isr;

  always #10 clk = ~clk;

  rdma_port #(.AW(16), .MEM_BYTES(MB), .PROM_BYTES(PB), .PMEM_START(PS)) uut (.*);

  always_comb
    for (int i = 0; i < 4; i++)
      mem_rdata[8*i +: 8] = (int'(mem_addr) + i < MB) ? mem[int'(mem_addr) + i] : 8'h00;

  always @(posedge clk)
    if (mem_we)
      for (int i = 0; i < 4; i++)
        if (mem_wmask[i] && int'(mem_addr) + i < MB) mem[int'(mem_addr) + i] <= mem_wdata[8*i +: 8];

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic bit valid(int a);
    return a < PB || (a >= PS && a < MB);
  endfunction

  task automatic pulse_ld(ref logic strobe, input logic [7:0] v);
    @(negedge clk); ld_data = v; strobe = 1;
    @(negedge clk); strobe = 0;
  endtask

  task automatic set_sar(logic [15:0] v);
    @(negedge clk); ld_data = v[7:0]; sar_lo_ld = 1;
    @(negedge clk); sar_lo_ld = 0; ld_data = v[15:8]; sar_hi_ld = 1;
    @(negedge clk); sar_hi_ld = 0;
    e_sar = v;
  endtask

  task automatic set_cnt(logic [15:0] v);
    @(negedge clk); ld_data = v[7:0]; cnt_lo_ld = 1;
    @(negedge clk); cnt_lo_ld = 0; ld_data = v[15:8]; cnt_hi_ld = 1;
    @(negedge clk); cnt_hi_ld = 0;
    e_cnt = v;
  endtask

  task automatic access(bit wr, logic [1:0] sz, logic [31:0] wd, string req);
    int n, b, s;
    logic [31:0] exp;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    b = (sz == 0) ? int'(e_sar) : int'(e_sar) & ~1;
    exp = 0;
    for (int i = 0; i < n; i++) exp[8*i +: 8] = valid(b + i) ? shadow[b + i] : 8'hFF;
    @(negedge clk);
    host_size = sz; host_wdata = wd; host_rd = !wr; host_wr = wr;
    #1;
    if (!wr) check({req, " rdata"}, host_rdata, exp);
    if (!wr || e_cnt != 0) begin
      if (wr) for (int i = 0; i < n; i++) if (valid(b + i)) shadow[b + i] = wd[8*i +: 8];
      s = int'(e_sar) + n;
      if (s[15:0] == {ring_stop, 8'h00}) s = {16'd0, ring_start, 8'h00};
      e_sar = s[15:0];
      if (int'(e_cnt) <= n) begin e_cnt = 0; e_isr[6] = 1; end
      else e_cnt = e_cnt - 16'(n);
    end
    @(negedge clk);
    host_rd = 0; host_wr = 0;
    check({req, " address"}, sar, e_sar);
    check({req, " count"}, cnt, e_cnt);
    check({req, " status"}, isr, e_isr);
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < MB; i++) begin mem[i] = 8'(i ^ 8'h5A); shadow[i] = 8'(i ^ 8'h5A); end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    e_sar = 0; e_cnt = 0; e_isr = 8'h80;
    check("R9 reset status", isr, 8'h80);
    check("R9 reset mask", imr, 8'h00);
    check("R9 reset command", cmd, 8'h22);
    check("R8 irq at reset", irq, 0);

    pulse_ld(cmd_ld, 8'h0A);
    e_isr = 8'h40;
    check("R6 remote read at zero count / R9 stop clear", isr, 8'h40);
    pulse_ld(isr_ld, 8'hFF); e_isr = 0;
    check("R7 write-one clear", isr, 8'h00);
    pulse_ld(cmd_ld, 8'h12);
    e_isr = 8'h40;
    check("R6 remote write at zero count", isr, 8'h40);
    pulse_ld(isr_ld, 8'h40); e_isr = 0;
    set_cnt(16'h0005);
    pulse_ld(cmd_ld, 8'h12);
    check("R6 no set with nonzero count", isr, 8'h00);

    for (int sz = 0; sz < 3; sz++) begin
      set_sar(16'h0240 + 16'(sz * 64)); set_cnt(16'd64);
      for (int k = 0; k < 64 >> sz; k++)
        access(1, 2'(sz), 32'hA0B1C2D3 ^ (32'(k) * 32'h01010101) ^ (32'(sz) << 28), "R2 write sweep");
      set_sar(16'h0240 + 16'(sz * 64)); set_cnt(16'd64);
      for (int k = 0; k < 64 >> sz; k++) access(0, 2'(sz), 0, "R2 read sweep");
      pulse_ld(isr_ld, 8'h7F); e_isr = 0;
    end

    set_sar(16'h0201); set_cnt(16'd10);
    access(0, 2'd1, 0, "R2 odd word alignment");
    access(0, 2'd3, 0, "R2 size three is doubleword");

    for (int a = 16'h0010; a < 16'h0030; a++)
      for (int sz = 0; sz < 3; sz++) begin
        set_sar(16'(a)); set_cnt(16'd100);
        access(0, 2'(sz), 0, "R1 prom window edge");
      end
    for (int a = PS - 6; a < PS + 4; a++)
      for (int sz = 0; sz < 3; sz++) begin
        set_sar(16'(a)); set_cnt(16'd100);
        access(0, 2'(sz), 0, "R1 packet window edge");
      end
    set_sar(16'h0100); set_cnt(16'd8);
    access(1, 2'd2, 32'h11223344, "R1 invalid write");
    check("R1 invalid write leaves memory", mem[16'h100], 8'(16'h100 ^ 16'h5A));
    set_sar(16'h03FE); set_cnt(16'd8);
    access(1, 2'd2, 32'hCAFEF00D, "R1 write crossing memory end");
    set_sar(16'h03FE); set_cnt(16'd8);
    access(0, 2'd2, 0, "R1 read crossing memory end");
    pulse_ld(isr_ld, 8'h7F); e_isr = 0;

    set_sar(16'h03FC); set_cnt(16'd40);
    access(0, 2'd2, 0, "R3 doubleword wrap");
    check("R3 wrapped to ring start", sar, 16'h0200);
    set_sar(16'h03FE);
    access(0, 2'd0, 0, "R3 byte before stop");
    access(0, 2'd0, 0, "R3 byte wrap");
    check("R3 byte wrapped", sar, 16'h0200);

    set_cnt(16'd3); set_sar(16'h0220);
    access(0, 2'd2, 0, "R4 count below size");
    pulse_ld(isr_ld, 8'h40); e_isr = 0;
    set_cnt(16'd2);
    access(1, 2'd1, 32'h0000BEEF, "R4 count equal size");
    pulse_ld(isr_ld, 8'h40); e_isr = 0;
    set_cnt(16'd5);
    access(0, 2'd1, 0, "R4 count above size");
    check("R4 count left", cnt, 16'd3);

    set_cnt(16'd0); set_sar(16'h0230);
    access(1, 2'd2, 32'hDEADBEEF, "R5 zero-count write");
    check("R5 memory untouched", mem[16'h230], 8'(16'h230 ^ 16'h5A));
    check("R5 address held", sar, 16'h0230);
    access(0, 2'd0, 0, "R4 read at zero count");
    pulse_ld(isr_ld, 8'h7F); e_isr = 0;

    pulse_ld(imr_ld, 8'h40);
    check("R8 masked clear keeps irq low", irq, 0);
    @(negedge clk); evt_set = 7'h41; @(negedge clk); evt_set = 0;
    e_isr = 8'h41;
    check("R7 event pulse sets bits", isr, 8'h41);
    check("R8 irq raised", irq, 1);
    @(negedge clk); evt_set = 7'h40; ld_data = 8'h41; isr_ld = 1;
    @(negedge clk); evt_set = 0; isr_ld = 0;
    check("R7 set wins over clear", isr, 8'h40);
    pulse_ld(isr_ld, 8'h40);
    check("R8 irq dropped", irq, 0);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    pulse_ld(imr_ld, 8'h80);
    check("R8 bit seven never interrupts", irq, 0);
    check("R9 status after second reset", isr, 8'h80);

    pulse_ld(sar_lo_ld, 8'h34);
    pulse_ld(sar_hi_ld, 8'h12);
    pulse_ld(sar_lo_ld, 8'h56);
    check("R10 address bytes", sar, 16'h1256);
    pulse_ld(cnt_hi_ld, 8'hAB);
    pulse_ld(cnt_lo_ld, 8'hCD);
    pulse_ld(cnt_hi_ld, 8'h01);
    check("R10 count bytes", cnt, 16'h01CD);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule